// File: doc/BRIEF.md
# Depth Tile Compression Mode Sequencer

This block is the control state machine in front of a depth-tile compressor. Each 8x8 tile of depth values is taken in through a ready/valid pair. The sequencer then runs one or more differential passes, each anchored on one corner pixel of the tile. The differential datapath is folded, so a pass takes two cycles, one per half of the differential set. After each pass, the sequencer spends one cycle sampling the break-point classifier. The arithmetic and the classifier sit outside this block. The sequencer only selects the reference corner, strobes the datapath and reads back a 3-bit class code.

The classification read after a pass decides which corner is tried next. Every pass starts from the upper-left corner:
- A one-plane tile goes straight to scheme selection and packing.
- A rising, vertical or horizontal tile gets a confirming pass from the lower-right corner.
- A tile that fails from the upper-left corner is retried from the lower-left corner. If that pass reports a falling case, it is confirmed from the upper-right corner.

A two-plane result passes through the combination stage. An uncompressed result bypasses it. Each outcome completes in a fixed number of cycles, and the final mode is reported together with `out_valid`.

States and transitions:
- `IDLE` goes to `UL0` when a tile is accepted.
- The upper-left pass runs `UL0 -> UL1 -> ULCHK`. From `ULCHK`:
  - one-plane goes to `SEL`;
  - rising, vertical or horizontal goes to `LR0`;
  - any other class goes to `LL0`.
- The lower-right pass runs `LR0 -> LR1 -> LRCHK`. From `LRCHK`:
  - a class that matches the stored case goes to `COMB`;
  - otherwise it goes to `PACK`.
- The lower-left pass runs `LL0 -> LL1 -> LLCHK`. From `LLCHK`:
  - falling goes to `UR0`;
  - otherwise it goes to `BYPASS`.
- The upper-right pass runs `UR0 -> UR1 -> URCHK`. From `URCHK`:
  - falling goes to `COMB`;
  - otherwise it goes to `PACK`.
- `BYPASS -> PACK`, `COMB -> SEL`, `SEL -> PACK` and `PACK -> IDLE`.

Top module: `depth_tile_mode_seq`

## Requirements
- R1: `in_ready` is high only while idle. A tile is accepted on a cycle where `tile_valid` and `in_ready` are both high. `tile_valid` asserted while a tile is in progress is ignored and does not start a later tile.
- R2: The first pass after acceptance uses the upper-left reference (`ref_sel` code 0). Every pass drives `diff_en` for two cycles with `diff_half` 0 then 1. It then drives `cls_take` for one cycle, with `ref_sel` held constant across all three cycles. The other reference codes are lower-right 1, lower-left 2 and upper-right 3.
- R3: Class codes on `bp_class` are: uncompressible 0, one-plane 1, rising 2, vertical 3, horizontal 4, falling 5. An upper-left class of 1 gives mode 1 with no combination cycle and one selection cycle. `out_valid` then rises in the 5th cycle after acceptance.
- R4: An upper-left class of 2, 3 or 4 triggers a lower-right pass. If that pass reports the same class, the mode equals that class. The sequence is one combination cycle, one selection cycle and `out_valid` in cycle 9.
- R5: If the lower-right class differs from the upper-left class, the mode is 0 (uncompressed). No combination or selection cycle is run, and `out_valid` rises in cycle 7.
- R6: An upper-left class of 0, 5, 6 or 7 triggers a lower-left pass. If that pass does not report 5, the mode is 0, the combination and selection stages are bypassed, and `out_valid` rises in cycle 8.
- R7: A lower-left class of 5 triggers an upper-right pass. If that also reports 5, the mode is 5, with one combination cycle, one selection cycle and `out_valid` in cycle 12.
- R8: If the upper-right pass does not report 5, the mode is 0. No combination or selection cycle is run, and `out_valid` rises in cycle 10.
- R9: At most one of `in_ready`, `diff_en`, `cls_take`, `comb_en`, `sel_en` and `out_valid` is high in any cycle. `comb_en` is high only when `mode` is a two-plane code (2 to 5).
- R10: `mode` does not change from the combination or selection cycle through `out_valid`. `out_valid` lasts one cycle and is followed by the idle state.
- R11: After reset, `in_ready` is 1, `mode` is 0, and `diff_en`, `cls_take`, `comb_en`, `sel_en` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tile_valid | input | 1 | A new tile is offered |
| in_ready | output | 1 | Sequencer idle, tile can be accepted |
| bp_class | input | 3 | Break-point classification of the pass just computed |
| ref_sel | output | 2 | Reference corner of the current pass |
| diff_en | output | 1 | Differential unit enable |
| diff_half | output | 1 | Which half of the differential set is computed |
| cls_take | output | 1 | Classification sampled this cycle |
| comb_en | output | 1 | Two-plane combination stage enable |
| sel_en | output | 1 | Scheme selection stage enable |
| out_valid | output | 1 | Packing stage enable; mode result valid |
| mode | output | 3 | Final tile mode code |

## Verification
The hardest paths to reach are those that need three passes, in particular the falling case rejected at the upper-right check. Reaching them requires the classifier to return a different class for each reference corner within one tile. The bench models the classifier as a function of `ref_sel`, so each table vector sets one class per corner, and the pass order, latency and stage-enable counts are then checked against each path.

// File: rtl/tms_pkg.sv
package tms_pkg;
    localparam int CLS_W  = 3;
    localparam int MODE_W = 3;
    localparam int REF_W  = 2;

    typedef enum logic [4:0] {
        S_IDLE, S_UL0, S_UL1, S_ULCHK,
        S_LR0,  S_LR1, S_LRCHK,
        S_LL0,  S_LL1, S_LLCHK,
        S_UR0,  S_UR1, S_URCHK,
        S_BYPASS, S_COMB, S_SEL, S_PACK
    } seq_state_t;

    localparam logic [REF_W-1:0] REF_UL = 2'd0;
    localparam logic [REF_W-1:0] REF_LR = 2'd1;
    localparam logic [REF_W-1:0] REF_LL = 2'd2;
    localparam logic [REF_W-1:0] REF_UR = 2'd3;

    localparam logic [CLS_W-1:0] CLS_NONE  = 3'd0;
    localparam logic [CLS_W-1:0] CLS_ONE   = 3'd1;
    localparam logic [CLS_W-1:0] CLS_RISE  = 3'd2;
    localparam logic [CLS_W-1:0] CLS_VERT  = 3'd3;
    localparam logic [CLS_W-1:0] CLS_HORIZ = 3'd4;
    localparam logic [CLS_W-1:0] CLS_FALL  = 3'd5;

    localparam logic [MODE_W-1:0] MODE_UNC = 3'd0;
endpackage

// File: rtl/tms_next_state.sv
module tms_next_state
    import tms_pkg::*;
(
    input  seq_state_t         state,
    input  logic               tile_valid,
    input  logic [CLS_W-1:0]   bp_class,
    input  logic [CLS_W-1:0]   case_q,
    input  logic [MODE_W-1:0]  mode_q,
    output seq_state_t         state_d,
    output logic [CLS_W-1:0]   case_d,
    output logic [MODE_W-1:0]  mode_d
);
    always_comb begin
        state_d = state;
        case_d  = case_q;
        mode_d  = mode_q;
        unique case (state)
            S_IDLE:   if (tile_valid) state_d = S_UL0;
            S_UL0:    state_d = S_UL1;
            S_UL1:    state_d = S_ULCHK;
            S_ULCHK: begin
                if (bp_class == CLS_ONE) begin
                    state_d = S_SEL;
                    mode_d  = CLS_ONE;
                end else if (bp_class == CLS_RISE || bp_class == CLS_VERT ||
                             bp_class == CLS_HORIZ) begin
                    state_d = S_LR0;
                    case_d  = bp_class;
                end else begin
                    state_d = S_LL0;
                end
            end
            S_LR0:    state_d = S_LR1;
            S_LR1:    state_d = S_LRCHK;
            S_LRCHK: begin
                if (bp_class == case_q) begin
                    state_d = S_COMB;
                    mode_d  = case_q;
                end else begin
                    state_d = S_PACK;
                    mode_d  = MODE_UNC;
                end
            end
            S_LL0:    state_d = S_LL1;
            S_LL1:    state_d = S_LLCHK;
            S_LLCHK: begin
                if (bp_class == CLS_FALL) begin
                    state_d = S_UR0;
                end else begin
                    state_d = S_BYPASS;
                    mode_d  = MODE_UNC;
                end
            end
            S_UR0:    state_d = S_UR1;
            S_UR1:    state_d = S_URCHK;
            S_URCHK: begin
                if (bp_class == CLS_FALL) begin
                    state_d = S_COMB;
                    mode_d  = CLS_FALL;
                end else begin
                    state_d = S_PACK;
                    mode_d  = MODE_UNC;
                end
            end
            S_BYPASS: state_d = S_PACK;
            S_COMB:   state_d = S_SEL;
            S_SEL:    state_d = S_PACK;
            S_PACK:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/tms_stage_decode.sv
module tms_stage_decode
    import tms_pkg::*;
(
    input  seq_state_t        state,
    output logic              in_ready,
    output logic [REF_W-1:0]  ref_sel,
    output logic              diff_en,
    output logic              diff_half,
    output logic              cls_take,
    output logic              comb_en,
    output logic              sel_en,
    output logic              out_valid
);
    always_comb begin
        in_ready  = 1'b0;
        ref_sel   = REF_UL;
        diff_en   = 1'b0;
        diff_half = 1'b0;
        cls_take  = 1'b0;
        comb_en   = 1'b0;
        sel_en    = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            S_IDLE:   in_ready = 1'b1;
            S_UL0:    begin ref_sel = REF_UL; diff_en = 1'b1; end
            S_UL1:    begin ref_sel = REF_UL; diff_en = 1'b1; diff_half = 1'b1; end
            S_ULCHK:  begin ref_sel = REF_UL; cls_take = 1'b1; end
            S_LR0:    begin ref_sel = REF_LR; diff_en = 1'b1; end
            S_LR1:    begin ref_sel = REF_LR; diff_en = 1'b1; diff_half = 1'b1; end
            S_LRCHK:  begin ref_sel = REF_LR; cls_take = 1'b1; end
            S_LL0:    begin ref_sel = REF_LL; diff_en = 1'b1; end
            S_LL1:    begin ref_sel = REF_LL; diff_en = 1'b1; diff_half = 1'b1; end
            S_LLCHK:  begin ref_sel = REF_LL; cls_take = 1'b1; end
            S_UR0:    begin ref_sel = REF_UR; diff_en = 1'b1; end
            S_UR1:    begin ref_sel = REF_UR; diff_en = 1'b1; diff_half = 1'b1; end
            S_URCHK:  begin ref_sel = REF_UR; cls_take = 1'b1; end
            S_BYPASS: ;
            S_COMB:   comb_en = 1'b1;
            S_SEL:    sel_en = 1'b1;
            S_PACK:   out_valid = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/depth_tile_mode_seq.sv
module depth_tile_mode_seq
    import tms_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tile_valid,
    output logic               in_ready,
    input  logic [CLS_W-1:0]   bp_class,
    output logic [REF_W-1:0]   ref_sel,
    output logic               diff_en,
    output logic               diff_half,
    output logic               cls_take,
    output logic               comb_en,
    output logic               sel_en,
    output logic               out_valid,
    output logic [MODE_W-1:0]  mode
);
    seq_state_t        state_q, state_d;
    logic [CLS_W-1:0]  case_q, case_d;
    logic [MODE_W-1:0] mode_q, mode_d;

    tms_next_state i_next (
        .state(state_q), .tile_valid(tile_valid), .bp_class(bp_class),
        .case_q(case_q), .mode_q(mode_q),
        .state_d(state_d), .case_d(case_d), .mode_d(mode_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            case_q  <= CLS_NONE;
            mode_q  <= MODE_UNC;
        end else begin
            state_q <= state_d;
            case_q  <= case_d;
            mode_q  <= mode_d;
        end
    end

    tms_stage_decode i_dec (
        .state(state_q), .in_ready(in_ready), .ref_sel(ref_sel),
        .diff_en(diff_en), .diff_half(diff_half), .cls_take(cls_take),
        .comb_en(comb_en), .sel_en(sel_en), .out_valid(out_valid)
    );

    assign mode = mode_q;

    // R1, R2: acceptance leads into the upper-left first half
    a_r1_first_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && tile_valid) |=> (diff_en && !diff_half && ref_sel == REF_UL));
    // R2: first half is followed by second half on the same reference
    a_r2_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_en && !diff_half) |=> (diff_en && diff_half && $stable(ref_sel)));
    // R2: second half is followed by the classification cycle
    a_r2_check_next: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_en && diff_half) |=> (cls_take && $stable(ref_sel)));
    // R9: stage enables never overlap
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_ready, diff_en, cls_take, comb_en, sel_en, out_valid}));
    // R9: combination only for two-plane modes
    a_r9_comb_mode: assert property (@(posedge clk) disable iff (!rst_n)
        comb_en |-> (mode >= CLS_RISE && mode <= CLS_FALL));
    // R10: mode held through late stages
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_en || sel_en) |=> $stable(mode));
    // R10: single-cycle result followed by idle
    a_r10_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (in_ready && !out_valid));
endmodule

// File: tb/test_depth_tile_mode_seq.sv
module test_depth_tile_mode_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tile_valid = 1'b0;
    logic       in_ready;
    logic [2:0] bp_class;
    logic [1:0] ref_sel;
    logic       diff_en, diff_half, cls_take, comb_en, sel_en, out_valid;
    logic [2:0] mode;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    depth_tile_mode_seq i_depth_tile_mode_seq (
        .clk(clk), .rst_n(rst_n), .tile_valid(tile_valid), .in_ready(in_ready),
        .bp_class(bp_class), .ref_sel(ref_sel), .diff_en(diff_en),
        .diff_half(diff_half), .cls_take(cls_take), .comb_en(comb_en),
        .sel_en(sel_en), .out_valid(out_valid), .mode(mode)
    );

    // Classifier model: one class per reference corner
    logic [2:0] c_ul, c_lr, c_ll, c_ur;
    always_comb begin
        case (ref_sel)
            2'd0:    bp_class = c_ul;
            2'd1:    bp_class = c_lr;
            2'd2:    bp_class = c_ll;
            default: bp_class = c_ur;
        endcase
    end

    typedef struct packed {
        logic [2:0] ca;    // upper-left class
        logic [2:0] cb;    // lower-right / lower-left class
        logic [2:0] cc;    // upper-right class
        logic [2:0] emode;
        logic [4:0] elat;
        logic [1:0] npass;
        logic [5:0] seq;   // pass refs, pass i at bits 2i+1:2i
        logic [1:0] ncomb;
        logic [1:0] nsel;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 3'd0, 3'd0, 3'd1, 5'd5,  2'd1, 6'd0,  2'd0, 2'd1}, // R3 one-plane
        '{3'd2, 3'd2, 3'd0, 3'd2, 5'd9,  2'd2, 6'd4,  2'd1, 2'd1}, // R4 rising
        '{3'd3, 3'd3, 3'd0, 3'd3, 5'd9,  2'd2, 6'd4,  2'd1, 2'd1}, // R4 vertical
        '{3'd4, 3'd4, 3'd0, 3'd4, 5'd9,  2'd2, 6'd4,  2'd1, 2'd1}, // R4 horizontal
        '{3'd2, 3'd3, 3'd0, 3'd0, 5'd7,  2'd2, 6'd4,  2'd0, 2'd0}, // R5 mismatch
        '{3'd4, 3'd2, 3'd0, 3'd0, 5'd7,  2'd2, 6'd4,  2'd0, 2'd0}, // R5 mismatch
        '{3'd0, 3'd0, 3'd0, 3'd0, 5'd8,  2'd2, 6'd8,  2'd0, 2'd0}, // R6 uncompressed
        '{3'd0, 3'd1, 3'd0, 3'd0, 5'd8,  2'd2, 6'd8,  2'd0, 2'd0}, // R6 lower-left not falling
        '{3'd5, 3'd0, 3'd0, 3'd0, 5'd8,  2'd2, 6'd8,  2'd0, 2'd0}, // R6 falling at upper-left
        '{3'd7, 3'd3, 3'd0, 3'd0, 5'd8,  2'd2, 6'd8,  2'd0, 2'd0}, // R6 unused code
        '{3'd0, 3'd5, 3'd5, 3'd5, 5'd12, 2'd3, 6'd56, 2'd1, 2'd1}, // R7 falling
        '{3'd6, 3'd5, 3'd5, 3'd5, 5'd12, 2'd3, 6'd56, 2'd1, 2'd1}, // R7 falling
        '{3'd0, 3'd5, 3'd4, 3'd0, 5'd10, 2'd3, 6'd56, 2'd0, 2'd0}  // R8 rejected
    };

    function automatic string tag_of(input logic [4:0] lat);
        case (lat)
            5'd5:    return "R3";
            5'd9:    return "R4";
            5'd7:    return "R5";
            5'd8:    return "R6";
            5'd12:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    int r_lat, r_np, r_comb, r_sel, r_takes;
    logic [5:0] r_seq;
    logic [2:0] r_mode;
    logic r_hung;

    task automatic run_tile(input logic [2:0] a, input logic [2:0] b,
                            input logic [2:0] c, input logic mid_pulse);
        c_ul = a; c_lr = b; c_ll = b; c_ur = c;
        r_lat = 0; r_np = 0; r_comb = 0; r_sel = 0; r_takes = 0;
        r_seq = '0; r_mode = '0; r_hung = 1'b0;
        @(negedge clk);
        tile_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tile_valid = 1'b0;
        forever begin
            r_lat++;
            if (diff_en && !diff_half) begin
                if (r_np < 3) r_seq[2*r_np +: 2] = ref_sel;
                r_np++;
            end
            if (cls_take) r_takes++;
            if (comb_en) r_comb++;
            if (sel_en) r_sel++;
            if (out_valid) begin
                r_mode = mode;
                break;
            end
            if (mid_pulse && r_lat == 4) begin
                chk(in_ready == 1'b0, "R1", "in_ready while busy", int'(in_ready), 0);
                tile_valid = 1'b1;
            end
            if (r_lat > 40) begin
                r_hung = 1'b1;
                break;
            end
            @(negedge clk);
            tile_valid = 1'b0;
        end
    endtask

    initial begin
        c_ul = 0; c_lr = 0; c_ll = 0; c_ur = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(in_ready == 1'b1, "R11", "in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R11", "out_valid", int'(out_valid), 0);
        chk({diff_en, cls_take, comb_en, sel_en} == 4'b0, "R11", "enables",
            int'({diff_en, cls_take, comb_en, sel_en}), 0);
        chk(mode == 3'd0, "R11", "mode", int'(mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "idle ready", int'(in_ready), 1);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = tag_of(v.elat);
            run_tile(v.ca, v.cb, v.cc, 1'b0);
            chk(!r_hung, t, "completion", int'(r_hung), 0);
            chk(r_mode == v.emode, t, "mode", int'(r_mode), int'(v.emode));
            chk(r_lat == int'(v.elat), t, "latency", r_lat, int'(v.elat));
            chk(r_np == int'(v.npass) && r_takes == int'(v.npass), "R2", "pass count",
                r_np * 10 + r_takes, int'(v.npass) * 11);
            chk(r_seq == v.seq, "R2", "reference order", int'(r_seq), int'(v.seq));
            chk(r_comb == int'(v.ncomb) && r_sel == int'(v.nsel), "R9", "comb/sel cycles",
                r_comb * 10 + r_sel, int'(v.ncomb) * 10 + int'(v.nsel));
            @(negedge clk);
            chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", "idle after result",
                int'({in_ready, out_valid}), 2);
        end

        // R1: tile_valid pulse mid-tile is ignored
        run_tile(3'd0, 3'd5, 3'd5, 1'b1);
        chk(r_mode == 3'd5 && r_lat == 12, "R1", "busy pulse disturbs tile",
            r_lat, 12);
        begin
            int stray;
            stray = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (diff_en || !in_ready) stray++;
            end
            chk(stray == 0, "R1", "stray tile start", stray, 0);
        end

        // R10: back-to-back tiles with tile_valid held
        c_ul = 3'd1;
        @(negedge clk);
        tile_valid = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 14; k++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            chk(seen == 2, "R10", "back-to-back results in 14 cycles", seen, 2);
        end
        tile_valid = 1'b0;
        repeat (8) @(negedge clk);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule